// File: doc/BRIEF.md
# Escape-prefixed command stream register decoder

This block takes a stream of bytes, one per accepted beat on a valid/ready pair, and decodes it into display-timing register writes. Each command opens with an escape byte and an opcode. The set-register command names an 8-bit index and supplies an 8-bit value. The copy command carries a source address, a pixel count and a destination address. The decoder only parses the copy command and reports its fields on a one-cycle strobe. It moves no pixels.

There are two register banks, a shadow bank and a live bank. A write always lands in the shadow bank. While the decoder is unlocked, the write also lands in the live bank at once. An in-band lock command freezes the live bank. The matching unlock command then copies the whole shadow bank into the live bank in one cycle, so a full mode change appears atomically. The live bank is exported flat. A few fields that neighbouring logic decodes are also exported pre-assembled: the colour-depth select, two 24-bit segment base addresses and one 16-bit word that is stored low byte first.

Top module: `cmd_reg_decoder`

## Requirements
- R1: After reset every live register reads zero, `locked`, `apply_pulse`, `err_flag` and `copy_valid` are low, and `in_ready` is high. A byte presented with `in_valid` low is not consumed.
- R2: The byte sequence 0xAF, 0x20, index, value writes value to register index. While the decoder is unlocked, the new value is visible on `live_regs[index*8 +: 8]` in the cycle after the value byte is accepted.
- R3: The set-register write of value 0x00 to index 0xFF sets `locked`. While locked, a write to an index below NUM_REGS changes only the shadow bank, and `live_regs` stays unchanged.
- R4: The set-register write of value 0xFF to index 0xFF clears `locked`, copies every shadow register into the live bank in a single cycle, and raises `apply_pulse` for exactly one cycle after the value byte is accepted.
- R5: A write to index 0xFF with any value other than 0x00 or 0xFF leaves `locked` and `live_regs` unchanged.
- R6: `mode_24bpp` is bit 0 of live register 0x00, where 0 selects 16 bits per pixel and 1 selects 24 bits per pixel.
- R7: `base16` is {reg 0x20, reg 0x21, reg 0x22} and `base8` is {reg 0x26, reg 0x27, reg 0x28}, with the most significant byte at the lowest index. `pix_clk` is {reg 0x1C, reg 0x1B}, with the low byte at the lower index.
- R8: The sequence 0xAF, 0x6A followed by seven bytes (three source address bytes with the high byte first, one count byte, three destination address bytes with the high byte first) raises `copy_valid` for one cycle after the last byte, with `copy_src`, `copy_count` and `copy_dst` holding those fields. The copy command leaves `live_regs` unchanged.
- R9: A byte other than 0xAF where a command should start, or an opcode other than 0x20 or 0x6A, sets `err_flag`. The flag stays set until reset. The parser resumes on the next 0xAF, and later well-formed commands take effect normally.
- R10: A set-register write to an index at or above NUM_REGS, other than 0xFF, changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte is valid |
| in_ready | output | 1 | Decoder accepts a byte (always high) |
| in_data | input | 8 | Input stream byte |
| live_regs | output | NUM_REGS*8 | Live register bank, register i at bits i*8+7..i*8 |
| locked | output | 1 | Live bank frozen by the lock command |
| apply_pulse | output | 1 | One-cycle pulse when the shadow bank has been applied |
| err_flag | output | 1 | Sticky framing or opcode error |
| copy_valid | output | 1 | One-cycle strobe for a decoded copy command |
| copy_src | output | 24 | Copy source address |
| copy_count | output | 8 | Copy pixel count |
| copy_dst | output | 24 | Copy destination address |
| mode_24bpp | output | 1 | Colour depth select from register 0x00 |
| base16 | output | 24 | 16-bpp segment base address |
| base8 | output | 24 | 8-bpp segment base address |
| pix_clk | output | 16 | Low-byte-first word from registers 0x1B/0x1C |

## Verification
The write path is tried with a table of unlocked writes. The table covers the lowest index, the highest in-range index and an index written twice, which separates a direct per-index write from stale or misaddressed storage. A lock, then several writes, then an unlock, separates the shadow and live banks: values must not appear early, and they must all appear together on the apply pulse. Writes to the control index with in-between values, writes to out-of-range indices and copy commands show that each of these leaves the bank alone. Stray bytes and unknown opcodes, each followed by a valid command, show that the error flag is sticky and that the parser recovers on the next escape byte.

// File: rtl/cmd_reg_decoder.sv
module cmd_reg_decoder #(
  parameter int NUM_REGS = 64,
  parameter logic [7:0] ESC_BYTE = 8'hAF,
  parameter logic [7:0] OP_SETREG = 8'h20,
  parameter logic [7:0] OP_COPY = 8'h6A,
  parameter logic [7:0] CTRL_IDX = 8'hFF,
  parameter int COPY_BYTES = 7
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [7:0]            in_data,
  output logic [NUM_REGS*8-1:0] live_regs,
  output logic                  locked,
  output logic                  apply_pulse,
  output logic                  err_flag,
  output logic                  copy_valid,
  output logic [23:0]           copy_src,
  output logic [7:0]            copy_count,
  output logic [23:0]           copy_dst,
  output logic                  mode_24bpp,
  output logic [23:0]           base16,
  output logic [23:0]           base8,
  output logic [15:0]           pix_clk
);
  localparam int CW = $clog2(COPY_BYTES + 1);
  localparam int SHW = (COPY_BYTES - 1) * 8;

  typedef enum logic [2:0] {S_HUNT, S_OPC, S_IDX, S_VAL, S_COPY} state_t;

  state_t           st;
  logic [7:0]       idx_q;
  logic [CW-1:0]    cpy_cnt;
  logic [SHW-1:0]   cpy_sh;
  logic [7:0]       shadow [NUM_REGS];
  logic [7:0]       live   [NUM_REGS];

  logic beat, wr_fire, is_ctrl, in_range, last_copy;
  logic [COPY_BYTES*8-1:0] cpy_full;

  assign in_ready  = 1'b1;
  assign beat      = in_valid;
  assign wr_fire   = beat && (st == S_VAL);
  assign is_ctrl   = (idx_q == CTRL_IDX);
  assign in_range  = (32'(idx_q) < NUM_REGS) && !is_ctrl;
  assign last_copy = beat && (st == S_COPY) && (cpy_cnt == CW'(COPY_BYTES - 1));
  assign cpy_full  = {cpy_sh, in_data};

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_HUNT;
      idx_q    <= '0;
      cpy_cnt  <= '0;
      cpy_sh   <= '0;
      err_flag <= 1'b0;
    end else if (beat) begin
      case (st)
        S_HUNT: begin
          if (in_data == ESC_BYTE) st <= S_OPC;
          else err_flag <= 1'b1;
        end
        S_OPC: begin
          cpy_cnt <= '0;
          if (in_data == OP_SETREG) st <= S_IDX;
          else if (in_data == OP_COPY) st <= S_COPY;
          else begin
            err_flag <= 1'b1;
            st       <= S_HUNT;
          end
        end
        S_IDX: begin
          idx_q <= in_data;
          st    <= S_VAL;
        end
        S_VAL: st <= S_HUNT;
        S_COPY: begin
          cpy_sh  <= {cpy_sh[SHW-9:0], in_data};
          cpy_cnt <= cpy_cnt + 1'b1;
          if (last_copy) st <= S_HUNT;
        end
        default: st <= S_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      locked      <= 1'b0;
      apply_pulse <= 1'b0;
      for (int i = 0; i < NUM_REGS; i++) begin
        shadow[i] <= '0;
        live[i]   <= '0;
      end
    end else begin
      apply_pulse <= 1'b0;
      if (wr_fire && in_range) begin
        shadow[idx_q[$clog2(NUM_REGS)-1:0]] <= in_data;
        if (!locked) live[idx_q[$clog2(NUM_REGS)-1:0]] <= in_data;
      end
      if (wr_fire && is_ctrl && in_data == 8'h00) locked <= 1'b1;
      if (wr_fire && is_ctrl && in_data == 8'hFF) begin
        locked      <= 1'b0;
        apply_pulse <= 1'b1;
        for (int i = 0; i < NUM_REGS; i++) live[i] <= shadow[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      copy_valid <= 1'b0;
      copy_src   <= '0;
      copy_count <= '0;
      copy_dst   <= '0;
    end else begin
      copy_valid <= last_copy;
      if (last_copy) begin
        copy_src   <= cpy_full[55:32];
        copy_count <= cpy_full[31:24];
        copy_dst   <= cpy_full[23:0];
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_REGS; g++) begin : g_flat
      assign live_regs[g*8 +: 8] = live[g];
    end
  endgenerate

  assign mode_24bpp = live[8'h00][0];
  assign base16     = {live[8'h20], live[8'h21], live[8'h22]};
  assign base8      = {live[8'h26], live[8'h27], live[8'h28]};
  assign pix_clk    = {live[8'h1C], live[8'h1B]};

  AST_APPLY_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    apply_pulse |=> !apply_pulse); // R4
  AST_APPLY_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
    apply_pulse |-> !locked); // R4
  AST_LOCKED_LIVE_STABLE: assert property (@(posedge clk) disable iff (rst)
    ($past(locked) && !apply_pulse) |-> $stable(live_regs)); // R3
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag); // R9
  AST_COPY_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    copy_valid |=> !copy_valid); // R8
endmodule

// File: tb/cmd_reg_decoder_tb.sv
module cmd_reg_decoder_tb_top;
  localparam int NR = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, locked, apply_pulse, err_flag, copy_valid, mode_24bpp;
  logic [NR*8-1:0] live_regs;
  logic [23:0] copy_src, copy_dst, base16, base8;
  logic [7:0] copy_count;
  logic [15:0] pix_clk;

  int n_cmp = 0;
  int n_bad = 0;
  logic [NR*8-1:0] snap;

  cmd_reg_decoder #(.NUM_REGS(NR)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .live_regs(live_regs), .locked(locked),
    .apply_pulse(apply_pulse), .err_flag(err_flag), .copy_valid(copy_valid),
    .copy_src(copy_src), .copy_count(copy_count), .copy_dst(copy_dst),
    .mode_24bpp(mode_24bpp), .base16(base16), .base8(base8), .pix_clk(pix_clk)
  );

  always #10 clk = ~clk;

  // {index, value, expected live value at index}
  localparam logic [23:0] VEC [0:7] = '{
    {8'h01, 8'h11, 8'h11}, {8'h00, 8'h5A, 8'h5A}, {8'h3F, 8'hC3, 8'hC3},
    {8'h10, 8'h01, 8'h01}, {8'h10, 8'hFE, 8'hFE}, {8'h02, 8'h80, 8'h80},
    {8'h3E, 8'h7F, 8'h7F}, {8'h07, 8'h00, 8'h00}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    in_data  = b;
    in_valid = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic setreg(input logic [7:0] idx, input logic [7:0] val);
    send(8'hAF); send(8'h20); send(idx); send(val);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    rst = 1'b0;
  endtask

  function automatic logic [7:0] lreg(input int i);
    return live_regs[i*8 +: 8];
  endfunction

  initial begin
    do_reset();
    chk("R1 live zero", 64'(live_regs == '0), 64'd1);
    chk("R1 locked", 64'(locked), 64'd0);
    chk("R1 apply", 64'(apply_pulse), 64'd0);
    chk("R1 err", 64'(err_flag), 64'd0);
    chk("R1 copy_valid", 64'(copy_valid), 64'd0);
    chk("R1 in_ready", 64'(in_ready), 64'd1);

    // R1: bytes with in_valid low are not consumed
    in_data = 8'h33;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 idle no err", 64'(err_flag), 64'd0);

    for (int k = 0; k < 8; k++) begin
      setreg(VEC[k][23:16], VEC[k][15:8]);
      chk("R2 table write", 64'(lreg(int'(VEC[k][23:16]))), 64'(VEC[k][7:0]));
    end
    chk("R2 overwrite kept", 64'(lreg(8'h10)), 64'hFE);

    // R3 / R4 lock then unlock
    setreg(8'hFF, 8'h00);
    chk("R3 locked set", 64'(locked), 64'd1);
    snap = live_regs;
    setreg(8'h05, 8'h77);
    setreg(8'h01, 8'h99);
    chk("R3 live frozen", 64'(live_regs == snap), 64'd1);
    setreg(8'hFF, 8'h5C);
    chk("R5 still locked", 64'(locked), 64'd1);
    chk("R5 live unchanged", 64'(live_regs == snap), 64'd1);
    send(8'hAF); send(8'h20); send(8'hFF);
    chk("R4 no early apply", 64'(apply_pulse), 64'd0);
    send(8'hFF);
    chk("R4 apply pulse", 64'(apply_pulse), 64'd1);
    chk("R4 unlocked", 64'(locked), 64'd0);
    chk("R4 reg5 applied", 64'(lreg(5)), 64'h77);
    chk("R4 reg1 applied", 64'(lreg(1)), 64'h99);
    @(posedge clk); #1;
    chk("R4 apply one cycle", 64'(apply_pulse), 64'd0);

    // R5 control write while unlocked
    snap = live_regs;
    setreg(8'hFF, 8'h01);
    chk("R5 not locked", 64'(locked), 64'd0);
    chk("R5 bank same", 64'(live_regs == snap), 64'd1);

    // R6 / R7 derived fields
    setreg(8'h00, 8'h01);
    chk("R6 24bpp", 64'(mode_24bpp), 64'd1);
    setreg(8'h00, 8'h00);
    chk("R6 16bpp", 64'(mode_24bpp), 64'd0);
    setreg(8'h20, 8'h12); setreg(8'h21, 8'h34); setreg(8'h22, 8'h56);
    setreg(8'h26, 8'hAB); setreg(8'h27, 8'hCD); setreg(8'h28, 8'hEF);
    setreg(8'h1B, 8'h34); setreg(8'h1C, 8'h12);
    chk("R7 base16", 64'(base16), 64'h123456);
    chk("R7 base8", 64'(base8), 64'hABCDEF);
    chk("R7 pix_clk", 64'(pix_clk), 64'h1234);

    // R8 copy command
    snap = live_regs;
    send(8'hAF); send(8'h6A);
    send(8'h01); send(8'h02); send(8'h03); send(8'h40);
    send(8'h0A); send(8'h0B);
    chk("R8 no early strobe", 64'(copy_valid), 64'd0);
    send(8'h0C);
    chk("R8 strobe", 64'(copy_valid), 64'd1);
    chk("R8 src", 64'(copy_src), 64'h010203);
    chk("R8 count", 64'(copy_count), 64'h40);
    chk("R8 dst", 64'(copy_dst), 64'h0A0B0C);
    chk("R8 bank same", 64'(live_regs == snap), 64'd1);
    @(posedge clk); #1;
    chk("R8 strobe one cycle", 64'(copy_valid), 64'd0);
    chk("R8 no err", 64'(err_flag), 64'd0);

    // R10 out-of-range index
    snap = live_regs;
    setreg(8'h40, 8'h66);
    setreg(8'hFE, 8'h66);
    chk("R10 bank same", 64'(live_regs == snap), 64'd1);

    // R9 stray byte then recovery
    send(8'h55);
    chk("R9 stray err", 64'(err_flag), 64'd1);
    setreg(8'h06, 8'h42);
    chk("R9 recover write", 64'(lreg(6)), 64'h42);
    chk("R9 sticky", 64'(err_flag), 64'd1);

    // R9 unknown opcode after fresh reset
    do_reset();
    chk("R1 reset clears", 64'(live_regs == '0), 64'd1);
    send(8'hAF); send(8'h33);
    chk("R9 bad opcode", 64'(err_flag), 64'd1);
    setreg(8'h08, 8'h24);
    chk("R9 resync write", 64'(lreg(8)), 64'h24);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule